// File: doc/BRIEF.md
# Low-Frequency Tag Wake-Up Pulse Sequencer

This block wakes one family of low-frequency tags. It then opens a bounded window in which the reader captures the tag's reply. A single start strobe launches the run. First the reader field is switched on and held on while the resonant antenna settles. Next comes an asymmetric preamble of four field-on pulses: short, long, short, long. Each pair of pulses is separated by a fixed field-off gap. After the last pulse the field stays on for a programmable read gap. Capture enable is then raised until a fixed number of sample strobes has arrived. At that point the field drops and a one-clock done pulse is issued.

All durations are counted in ticks of an external microsecond strobe, so the timing does not depend on the system clock rate. Carrier generation and the storage of captured samples belong to neighbouring blocks. The defaults give a 50 ms settle time, pulses of 800 µs and 3600 µs, gaps of 2200 µs and 20000 captured samples.

Top module: `lfw_wake_seq`

## Requirements
- R1: While reset is asserted, and in the first clock after it, field_en_o, capture_en_o, busy_o and done_o are all low.
- R2: A start_i pulse while idle raises busy_o and field_en_o in the next clock. The field then stays on continuously for SETTLE_US + SHORT_US ticks of us_tick_i, which covers the settle time followed directly by the first pulse.
- R3: After the first pulse, the field goes off for GAP_US ticks, on for LONG_US, off for GAP_US, on for SHORT_US, off for GAP_US, and then on for the fourth pulse. The field changes exactly seven times before capture begins.
- R4: The fourth pulse and the read gap form one field-on stretch of LONG_US + read_gap_us_i ticks. A read gap of zero starts capture directly after the fourth pulse.
- R5: capture_en_o stays high, with the field on, until exactly SAMPLE_COUNT sample_stb_i pulses have arrived. Sample strobes outside the capture window have no effect.
- R6: done_o is high for exactly one clock per run. That clock is the first clock with field_en_o, capture_en_o and busy_o all low.
- R7: A start_i pulse while busy_o is high is ignored. The run in progress keeps its timing, and no second run follows.
- R8: capture_en_o is never high without field_en_o. Whenever busy_o is low, field_en_o is low.
- R9: A phase ends in the clock that consumes its last tick. A tick is counted only in a clock where us_tick_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, one clock wide |
| us_tick_i | input | 1 | One-clock strobe per microsecond |
| sample_stb_i | input | 1 | One-clock strobe per captured sample |
| read_gap_us_i | input | GAP_W | Field-on time after the fourth pulse, in ticks |
| field_en_o | output | 1 | Reader field enable |
| capture_en_o | output | 1 | Capture window open |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-clock pulse when the field turns off |

## Verification
The hardest cases to reach from the ports are the phase boundaries: the clock in which a last tick, a sample strobe and a start strobe all meet a change of phase. A zero read gap is one such case, because the fourth pulse then hands over directly to capture. The bench uses a small configuration and sweeps the tick divisor, the strobe cadence and the read gap. Each phase edge therefore falls on a different alignment of tick and strobe. Extra start strobes are injected during the preamble. The bench measures every field-on and field-off stretch in consumed ticks and compares it with sums computed from the parameters.

// File: rtl/lfw_pkg.sv
package lfw_pkg;

   typedef enum logic [3:0] {
      PH_IDLE,
      PH_SETTLE,
      PH_PULSE0,
      PH_GAP0,
      PH_PULSE1,
      PH_GAP1,
      PH_PULSE2,
      PH_GAP2,
      PH_PULSE3,
      PH_READ_GAP,
      PH_CAPTURE
   } lfw_phase_e;

   // Number of field-on pulses in the wake preamble.
   localparam int LFW_NUM_PULSES = 4;

   function automatic logic lfw_field_on(lfw_phase_e p);
      return !(p inside {PH_IDLE, PH_GAP0, PH_GAP1, PH_GAP2});
   endfunction

endpackage

// File: rtl/lfw_interval_timer.sv
module lfw_interval_timer #(
   parameter int TMR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [TMR_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic             last_o
);

   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   logic [TMR_W-1:0] remain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load_i) begin
         remain_q <= load_val_i;
      end else if (tick_i && (remain_q != '0)) begin
         remain_q <= remain_q - ONE;
      end
   end

   // The phase ends in the clock that consumes its final tick.
   assign last_o = tick_i && (remain_q == ONE);

endmodule

// File: rtl/lfw_sample_window.sv
module lfw_sample_window #(
   parameter int COUNT = 20000,
   parameter int CNT_W = 15
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic enable_i,
   input  logic stb_i,
   output logic last_o
);

   generate
      if (COUNT == 1) begin : g_single
         // A window of one sample needs no counter.
         logic unused_single;
         assign unused_single = ^{clk, rst_n, arm_i};
         assign last_o = enable_i && stb_i;
      end else begin : g_counted
         localparam logic [CNT_W-1:0] LOAD = CNT_W'(COUNT);
         localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

         logic [CNT_W-1:0] left_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               left_q <= '0;
            end else if (arm_i) begin
               left_q <= LOAD;
            end else if (enable_i && stb_i && (left_q != '0)) begin
               left_q <= left_q - ONE;
            end
         end

         assign last_o = enable_i && stb_i && (left_q == ONE);
      end
   endgenerate

endmodule

// File: rtl/lfw_phase_seq.sv
module lfw_phase_seq
   import lfw_pkg::*;
#(
   parameter int SETTLE_US = 50000,
   parameter int SHORT_US  = 800,
   parameter int LONG_US   = 3600,
   parameter int GAP_US    = 2200,
   parameter int GAP_W     = 16,
   parameter int TMR_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [GAP_W-1:0] read_gap_i,
   input  logic             tmr_last_i,
   input  logic             smp_last_i,
   output logic             tmr_load_o,
   output logic [TMR_W-1:0] tmr_val_o,
   output logic             smp_arm_o,
   output lfw_phase_e       phase_o,
   output logic             done_o
);

   localparam logic [TMR_W-1:0] SETTLE_LEN = TMR_W'(SETTLE_US);
   localparam logic [TMR_W-1:0] GAP_LEN    = TMR_W'(GAP_US);

   // Pulse lengths alternate short/long, starting with short.
   logic [TMR_W-1:0] pulse_len [LFW_NUM_PULSES];
   for (genvar i = 0; i < LFW_NUM_PULSES; i++) begin : g_pulse
      if ((i % 2) == 0) begin : g_short
         assign pulse_len[i] = TMR_W'(SHORT_US);
      end else begin : g_long
         assign pulse_len[i] = TMR_W'(LONG_US);
      end
   end

   lfw_phase_e phase_q, phase_d;
   logic       done_q, done_d;

   always_comb begin
      phase_d    = phase_q;
      tmr_load_o = 1'b0;
      tmr_val_o  = '0;
      smp_arm_o  = 1'b0;
      done_d     = 1'b0;
      unique case (phase_q)
         PH_IDLE: if (start_i) begin
            phase_d    = PH_SETTLE;
            tmr_load_o = 1'b1;
            tmr_val_o  = SETTLE_LEN;
         end
         PH_SETTLE: if (tmr_last_i) begin
            phase_d    = PH_PULSE0;
            tmr_load_o = 1'b1;
            tmr_val_o  = pulse_len[0];
         end
         PH_PULSE0: if (tmr_last_i) begin
            phase_d    = PH_GAP0;
            tmr_load_o = 1'b1;
            tmr_val_o  = GAP_LEN;
         end
         PH_GAP0: if (tmr_last_i) begin
            phase_d    = PH_PULSE1;
            tmr_load_o = 1'b1;
            tmr_val_o  = pulse_len[1];
         end
         PH_PULSE1: if (tmr_last_i) begin
            phase_d    = PH_GAP1;
            tmr_load_o = 1'b1;
            tmr_val_o  = GAP_LEN;
         end
         PH_GAP1: if (tmr_last_i) begin
            phase_d    = PH_PULSE2;
            tmr_load_o = 1'b1;
            tmr_val_o  = pulse_len[2];
         end
         PH_PULSE2: if (tmr_last_i) begin
            phase_d    = PH_GAP2;
            tmr_load_o = 1'b1;
            tmr_val_o  = GAP_LEN;
         end
         PH_GAP2: if (tmr_last_i) begin
            phase_d    = PH_PULSE3;
            tmr_load_o = 1'b1;
            tmr_val_o  = pulse_len[3];
         end
         PH_PULSE3: if (tmr_last_i) begin
            if (read_gap_i == '0) begin
               phase_d   = PH_CAPTURE;
               smp_arm_o = 1'b1;
            end else begin
               phase_d    = PH_READ_GAP;
               tmr_load_o = 1'b1;
               tmr_val_o  = TMR_W'(read_gap_i);
            end
         end
         PH_READ_GAP: if (tmr_last_i) begin
            phase_d   = PH_CAPTURE;
            smp_arm_o = 1'b1;
         end
         PH_CAPTURE: if (smp_last_i) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done_q  <= 1'b0;
      end else begin
         phase_q <= phase_d;
         done_q  <= done_d;
      end
   end

   assign phase_o = phase_q;
   assign done_o  = done_q;

endmodule

// File: rtl/lfw_wake_seq.sv
module lfw_wake_seq
   import lfw_pkg::*;
#(
   parameter int SETTLE_US    = 50000,
   parameter int SHORT_US     = 800,
   parameter int LONG_US      = 3600,
   parameter int GAP_US       = 2200,
   parameter int SAMPLE_COUNT = 20000,
   parameter int GAP_W        = 16,
   parameter int TMR_W        = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             us_tick_i,
   input  logic             sample_stb_i,
   input  logic [GAP_W-1:0] read_gap_us_i,
   output logic             field_en_o,
   output logic             capture_en_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam int SMP_W   = (SAMPLE_COUNT > 1) ? $clog2(SAMPLE_COUNT + 1) : 1;
   localparam int TMR_MAX = (1 << TMR_W) - 1;

   // Elaboration-time parameter checks.
   if (TMR_W < GAP_W) begin : g_chk_gap_w
      $error("lfw_wake_seq: TMR_W must hold a full read gap");
   end
   if ((SETTLE_US < 1) || (SETTLE_US > TMR_MAX)) begin : g_chk_settle
      $error("lfw_wake_seq: SETTLE_US out of timer range");
   end
   if ((SHORT_US < 1) || (LONG_US < 1) || (GAP_US < 1) ||
       (SHORT_US > TMR_MAX) || (LONG_US > TMR_MAX) || (GAP_US > TMR_MAX)) begin : g_chk_pre
      $error("lfw_wake_seq: preamble durations out of timer range");
   end
   if (SAMPLE_COUNT < 1) begin : g_chk_smp
      $error("lfw_wake_seq: SAMPLE_COUNT must be at least one");
   end

   lfw_phase_e       phase;
   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_last;
   logic             smp_arm;
   logic             smp_last;
   logic             done;

   lfw_phase_seq #(
      .SETTLE_US (SETTLE_US),
      .SHORT_US  (SHORT_US),
      .LONG_US   (LONG_US),
      .GAP_US    (GAP_US),
      .GAP_W     (GAP_W),
      .TMR_W     (TMR_W)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .read_gap_i (read_gap_us_i),
      .tmr_last_i (tmr_last),
      .smp_last_i (smp_last),
      .tmr_load_o (tmr_load),
      .tmr_val_o  (tmr_val),
      .smp_arm_o  (smp_arm),
      .phase_o    (phase),
      .done_o     (done)
   );

   lfw_interval_timer #(
      .TMR_W (TMR_W)
   ) tmr_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .tick_i     (us_tick_i),
      .last_o     (tmr_last)
   );

   lfw_sample_window #(
      .COUNT (SAMPLE_COUNT),
      .CNT_W (SMP_W)
   ) win_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (smp_arm),
      .enable_i (phase == PH_CAPTURE),
      .stb_i    (sample_stb_i),
      .last_o   (smp_last)
   );

   assign field_en_o   = lfw_field_on(phase);
   assign capture_en_o = (phase == PH_CAPTURE);
   assign busy_o       = (phase != PH_IDLE);
   assign done_o       = done;

endmodule

// File: rtl/lfw_wake_seq_chk.sv
module lfw_wake_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic field_en_o,
   input logic capture_en_o,
   input logic busy_o,
   input logic done_o
);

   // R8: capture only with the field on
   a_r8_capture_needs_field: assert property (@(posedge clk) disable iff (!rst_n)
      capture_en_o |-> field_en_o);

   // R8: idle means field off
   a_r8_idle_field_off: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !field_en_o && !capture_en_o);

   // R6: done lasts one clock
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R6: done follows the capture window and marks field off
   a_r6_done_after_capture: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && !field_en_o && $past(capture_en_o));

   // R5: the capture window closes only together with done
   a_r5_capture_end_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(capture_en_o) |-> done_o);

   // R2: a run opens with the field on and capture closed
   a_r2_start_field_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> field_en_o && !capture_en_o);

   // R2: a start while idle always launches a run
   a_r2_idle_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && start_i |=> busy_o);

   // R7: a run never ends before the capture window
   a_r7_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !capture_en_o |=> busy_o);

endmodule

bind lfw_wake_seq lfw_wake_seq_chk chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start_i      (start_i),
   .field_en_o   (field_en_o),
   .capture_en_o (capture_en_o),
   .busy_o       (busy_o),
   .done_o       (done_o)
);

// File: tb/lfw_wake_seq_tb_top.sv
module lfw_wake_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 5;
   localparam int SHORT      = 2;
   localparam int LONG       = 4;
   localparam int GAP        = 3;
   localparam int SAMPLES    = 6;
   localparam int GW         = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          us_tick = 1'b0;
   logic          sample_stb = 1'b0;
   logic [GW-1:0] read_gap = '0;
   logic          field_en, capture_en, busy, done;

   lfw_wake_seq #(
      .SETTLE_US    (SETTLE),
      .SHORT_US     (SHORT),
      .LONG_US      (LONG),
      .GAP_US       (GAP),
      .SAMPLE_COUNT (SAMPLES),
      .GAP_W        (GW),
      .TMR_W        (16)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start),
      .us_tick_i     (us_tick),
      .sample_stb_i  (sample_stb),
      .read_gap_us_i (read_gap),
      .field_en_o    (field_en),
      .capture_en_o  (capture_en),
      .busy_o        (busy),
      .done_o        (done)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   int   tick_div = 1;
   int   stb_div = 1;
   bit   mon_en = 1'b0;
   int   seg = 0;
   int   seg_ticks [8];
   int   seg_stb [8];
   bit   seg_fld [8];
   bit   seg_cap [8];
   int   seg_over = 0;
   int   done_cnt = 0;
   int   done_bad = 0;
   bit   prev_busy = 1'b0;
   logic [1:0] prev_fc = 2'b00;

   task automatic check(input bit ok, input string req, input int act, input int exp,
                        input string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Observe the state shown now together with the tick and strobe it will consume
   // at the next rising edge, then drive those inputs.
   always @(negedge clk) begin
      logic nt, ns;
      cyc++;
      nt = ((cyc % tick_div) == 0);
      ns = ((cyc % stb_div) == 0);
      if (mon_en) begin
         if (busy) begin
            if (!prev_busy) seg = 0;
            else if ({field_en, capture_en} != prev_fc) seg++;
            if (seg < 8) begin
               seg_ticks[seg] += int'(nt);
               seg_stb[seg]   += int'(ns);
               seg_fld[seg]   = field_en;
               seg_cap[seg]   = capture_en;
            end else begin
               seg_over++;
            end
         end
         if (done) begin
            done_cnt++;
            if (busy || field_en || capture_en) done_bad++;
         end
      end
      prev_busy  = busy;
      prev_fc    = {field_en, capture_en};
      us_tick    = nt;
      sample_stb = ns;
   end

   task automatic run_one(input int gap, input int td, input int sd, input bit spam);
      int exp_t [7];
      int w;
      read_gap = GW'(gap);
      tick_div = td;
      stb_div  = sd;
      for (int k = 0; k < 8; k++) begin
         seg_ticks[k] = 0;
         seg_stb[k]   = 0;
         seg_fld[k]   = 1'b0;
         seg_cap[k]   = 1'b0;
      end
      seg = 0;
      seg_over = 0;
      done_cnt = 0;
      done_bad = 0;
      mon_en = 1'b1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (spam) begin
         for (int s = 0; s < 3; s++) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
         end
      end
      w = 0;
      while (done_cnt == 0 && w < 5000) begin
         @(posedge clk);
         w++;
      end
      repeat (3) @(posedge clk);
      mon_en = 1'b0;
      #1;
      check(w < 5000, "R5", w, 0, "run did not finish");
      exp_t[0] = SETTLE + SHORT;
      exp_t[1] = GAP;
      exp_t[2] = LONG;
      exp_t[3] = GAP;
      exp_t[4] = SHORT;
      exp_t[5] = GAP;
      exp_t[6] = LONG + gap;
      check(seg == 7 && seg_over == 0, "R3", seg, 7, "field stretches before idle");
      check(seg_ticks[0] == exp_t[0] && seg_fld[0] && !seg_cap[0], "R2", seg_ticks[0], exp_t[0],
            "settle plus first pulse ticks");
      for (int k = 1; k < 6; k++) begin
         check(seg_ticks[k] == exp_t[k] && seg_fld[k] == (k % 2 == 0) && !seg_cap[k], "R3",
               seg_ticks[k], exp_t[k], $sformatf("preamble stretch %0d ticks", k));
      end
      check(seg_ticks[6] == exp_t[6] && seg_fld[6] && !seg_cap[6], "R4", seg_ticks[6], exp_t[6],
            "fourth pulse plus read gap ticks");
      check(seg_stb[7] == SAMPLES && seg_fld[7] && seg_cap[7], "R5", seg_stb[7], SAMPLES,
            "strobes in capture window");
      check(done_cnt == 1, "R6", done_cnt, 1, "done pulse width");
      check(done_bad == 0, "R6", done_bad, 0, "outputs while done");
      check(!busy && !field_en && !done, spam ? "R7" : "R6", int'(busy), 0, "idle after run");
      if (spam) check(done_cnt == 1 && !busy, "R7", done_cnt, 1, "start while busy ignored");
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      check({field_en, capture_en, busy, done} == 4'b0, "R1",
            int'({field_en, capture_en, busy, done}), 0, "outputs in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check({field_en, capture_en, busy, done} == 4'b0, "R1",
            int'({field_en, capture_en, busy, done}), 0, "outputs after reset");
      // Strobes while idle must not start anything (R5, R9).
      repeat (10) @(negedge clk);
      check(!busy && !field_en, "R5", int'(busy), 0, "idle ignores ticks and strobes");

      for (int g = 0; g < 5; g++) begin
         for (int td = 1; td <= 3; td++) begin
            for (int sd = 1; sd <= 3; sd += 2) begin
               run_one(g, td, sd, ((g + td) % 2) == 1);
            end
         end
      end

      // Reset in the middle of a run returns every output low (R1).
      tick_div = 1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (12) @(negedge clk);
      check(busy, "R1", int'(busy), 1, "busy before mid-run reset");
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check({field_en, capture_en, busy, done} == 4'b0, "R1",
            int'({field_en, capture_en, busy, done}), 0, "outputs after mid-run reset");
      rst_n = 1'b1;
      @(negedge clk);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule